// File: doc/BRIEF.md
# Three-Wire Addressed Control-Register Receiver

This block receives control bytes for an audio converter over a write-only serial link. The link has three lines: data, clock and a mode line that separates the two phases of a transfer. When the mode line is low, one byte selects the device and picks which group of registers the following bytes will reach. When the mode line is high, each byte writes one register of that group. The receiver holds left and right volume, bass boost, treble, a two-bit operating mode, a de-emphasis flag and two-bit routing codes for each channel, and drives them on parallel outputs.

All three serial lines are first brought into the system clock domain. Bits are taken on each rising edge of the synchronized serial clock, most significant bit first. Nothing changes until a complete byte has arrived. A strap input selects a fixed-pin fallback. In that mode the three serial lines act as direct mute-left, mute-right and de-emphasis controls, and every stored register is held at its default.

Top module: `ctl3w_rx`

## Requirements
- R1: After reset every level, mode and routing output is zero, de-emphasis is 0 and both mutes are 0.
- R2: An address byte (mode line low) selects the block only when its bits 7..2 equal 6'b000101. With any other address, later data bytes change nothing until a matching address byte arrives.
- R3: When address bits 1..0 are 2'b00 (level group), bits 7..6 of each data byte choose the target and bits 5..0 give the value: 00 sets right volume, 01 sets left volume, 10 sets bass boost, 11 sets treble.
- R4: When address bits 1..0 are 2'b10 (status group), a data byte whose bit 7 is 0 writes all status fields at once: mode from bits 6..5, de-emphasis from bit 4, right routing from bits 3..2 and left routing from bits 1..0. A status byte whose bit 7 is 1 writes nothing.
- R5: When address bits 1..0 are 2'b01 or 2'b11, data bytes write nothing.
- R6: The device selection and group choice stay in force for any number of data bytes, until the next address byte.
- R7: A register changes only after the eighth bit of a byte. Any change of the mode line clears the bit count, so a byte that is only partly sent is dropped.
- R8: While the strap input is high, mute-left follows the data line, mute-right follows the mode line and de-emphasis follows the clock line (after synchronization). All stored registers read zero, and the selection is cleared.
- R9: Serial bits arrive most significant first. Bit 7 is the first bit clocked in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_static | input | 1 | High selects the fixed-pin fallback |
| ser_data | input | 1 | Serial data line |
| ser_mode | input | 1 | Serial mode line: low = address byte, high = data byte |
| ser_clk | input | 1 | Serial bit clock |
| vol_right | output | 6 | Right-channel volume |
| vol_left | output | 6 | Left-channel volume |
| bass_boost | output | 6 | Bass boost level |
| treble | output | 6 | Treble level |
| op_mode | output | 2 | Operating mode code |
| deemph | output | 1 | De-emphasis enable |
| route_right | output | 2 | Right-channel routing code |
| route_left | output | 2 | Left-channel routing code |
| mute_left | output | 1 | Left mute (fixed-pin mode only) |
| mute_right | output | 1 | Right mute (fixed-pin mode only) |

## Verification
The assertions assume that the serial lines are slow compared with the system clock, so that every level of the serial clock and mode line lasts long enough for the synchronizer to see it. They also assume the mode line only changes while the serial clock is low. The stimulus holds each serial half-period for four system clocks and changes data and mode only during the low phase. It returns the serial lines to idle before the strap input changes. Random bytes, random addresses and random group codes are mixed with directed cases: a dropped partial byte, a rejected status byte and a wrong address.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

    localparam int BYTE_W   = 8;
    localparam int VAL_W    = 6;
    localparam int ID_W     = 6;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam logic [ID_W-1:0] DEFAULT_ID = 6'b000101;

    typedef enum logic [1:0] {
        XFER_LEVELS = 2'b00,
        XFER_RSV_A  = 2'b01,
        XFER_STATUS = 2'b10,
        XFER_RSV_B  = 2'b11
    } xfer_e;

    typedef enum logic [1:0] {
        TGT_VOL_R  = 2'b00,
        TGT_VOL_L  = 2'b01,
        TGT_BASS   = 2'b10,
        TGT_TREBLE = 2'b11
    } level_tgt_e;

    typedef struct packed {
        logic [VAL_W-1:0] vol_r;
        logic [VAL_W-1:0] vol_l;
        logic [VAL_W-1:0] bass;
        logic [VAL_W-1:0] treble;
    } levels_t;

    typedef struct packed {
        logic [1:0] mode;
        logic       deemph;
        logic [1:0] route_r;
        logic [1:0] route_l;
    } status_t;

    typedef struct packed {
        logic [BYTE_W-1:0] bits;
        logic              is_addr;
    } rx_byte_t;

    typedef struct packed {
        logic dat;
        logic mode;
        logic sclk;
    } pins_t;

    localparam levels_t LEVELS_DEFAULT = '0;
    localparam status_t STATUS_DEFAULT = '0;

    function automatic logic id_match(input logic [BYTE_W-1:0] b,
                                      input logic [ID_W-1:0] id);
        return b[BYTE_W-1 -: ID_W] == id;
    endfunction

    function automatic level_tgt_e level_target(input logic [BYTE_W-1:0] b);
        return level_tgt_e'(b[BYTE_W-1 -: 2]);
    endfunction

    function automatic status_t status_decode(input logic [BYTE_W-1:0] b);
        return status_t'(b[BYTE_W-2:0]);
    endfunction

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter
    import ctl3w_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  pins_t    pins,
    output logic     byte_vld,
    output rx_byte_t byte_out
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sclk_q;
    logic              mode_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;
    logic              rise;
    logic              mode_chg;

    assign rise     = pins.sclk & ~sclk_q;
    assign mode_chg = pins.mode ^ mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            mode_q   <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_out <= '0;
        end else begin
            sclk_q   <= pins.sclk;
            mode_q   <= pins.mode;
            byte_vld <= 1'b0;
            if (clear || mode_chg) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= {shreg[BYTE_W-3:0], pins.dat};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt          <= '0;
                    byte_vld         <= 1'b1;
                    byte_out.bits    <= {shreg, pins.dat};
                    byte_out.is_addr <= ~pins.mode;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    AST_VLD_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(rise && !clear && !mode_chg)) else $error("vld without edge"); // R7
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld) else $error("vld longer than one cycle"); // R7
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
    import ctl3w_pkg::*;
#(
    parameter logic [ID_W-1:0] DEVICE_ID = DEFAULT_ID
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hold_defaults,
    input  logic     byte_vld,
    input  rx_byte_t byte_in,
    output levels_t  levels,
    output status_t  status
);
    logic  selected;
    xfer_e xfer;

    always_ff @(posedge clk) begin
        if (rst || hold_defaults) begin
            selected <= 1'b0;
            xfer     <= XFER_LEVELS;
            levels   <= LEVELS_DEFAULT;
            status   <= STATUS_DEFAULT;
        end else if (byte_vld) begin
            if (byte_in.is_addr) begin
                selected <= id_match(byte_in.bits, DEVICE_ID);
                xfer     <= xfer_e'(byte_in.bits[1:0]);
            end else if (selected) begin
                unique case (xfer)
                    XFER_LEVELS: begin
                        unique case (level_target(byte_in.bits))
                            TGT_VOL_R:  levels.vol_r  <= byte_in.bits[VAL_W-1:0];
                            TGT_VOL_L:  levels.vol_l  <= byte_in.bits[VAL_W-1:0];
                            TGT_BASS:   levels.bass   <= byte_in.bits[VAL_W-1:0];
                            TGT_TREBLE: levels.treble <= byte_in.bits[VAL_W-1:0];
                        endcase
                    end
                    XFER_STATUS: begin
                        if (!byte_in.bits[BYTE_W-1])
                            status <= status_decode(byte_in.bits);
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_LEVELS_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst || hold_defaults)
        (levels != $past(levels)) |-> $past(byte_vld && !byte_in.is_addr && selected && xfer == XFER_LEVELS))
        else $error("level write without selection"); // R2
    AST_STATUS_GUARD: assert property (@(posedge clk) disable iff (rst || hold_defaults)
        (status != $past(status)) |-> $past(byte_vld && !byte_in.is_addr && selected
                                            && xfer == XFER_STATUS && !byte_in.bits[BYTE_W-1]))
        else $error("status write not allowed"); // R4
    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst || hold_defaults)
        (byte_vld && !byte_in.is_addr && xfer[0]) |=> ($stable(levels) && $stable(status)))
        else $error("unused group wrote"); // R5
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
    import ctl3w_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [ID_W-1:0] DEVICE_ID   = DEFAULT_ID
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_static,
    input  logic             ser_data,
    input  logic             ser_mode,
    input  logic             ser_clk,
    output logic [VAL_W-1:0] vol_right,
    output logic [VAL_W-1:0] vol_left,
    output logic [VAL_W-1:0] bass_boost,
    output logic [VAL_W-1:0] treble,
    output logic [1:0]       op_mode,
    output logic             deemph,
    output logic [1:0]       route_right,
    output logic [1:0]       route_left,
    output logic             mute_left,
    output logic             mute_right
);
    localparam int PIN_W = $bits(pins_t);

    pins_t    raw_pins;
    pins_t    s_pins;
    logic     byte_vld;
    rx_byte_t rx_byte;
    levels_t  levels;
    status_t  status;

    assign raw_pins = '{dat: ser_data, mode: ser_mode, sclk: ser_clk};

    ctl3w_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (s_pins)
    );

    ctl3w_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (strap_static),
        .pins     (s_pins),
        .byte_vld (byte_vld),
        .byte_out (rx_byte)
    );

    ctl3w_regfile #(.DEVICE_ID(DEVICE_ID)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .hold_defaults (strap_static),
        .byte_vld      (byte_vld),
        .byte_in       (rx_byte),
        .levels        (levels),
        .status        (status)
    );

    assign vol_right   = levels.vol_r;
    assign vol_left    = levels.vol_l;
    assign bass_boost  = levels.bass;
    assign treble      = levels.treble;
    assign op_mode     = status.mode;
    assign route_right = status.route_r;
    assign route_left  = status.route_l;
    assign deemph      = strap_static ? s_pins.sclk : status.deemph;
    assign mute_left   = strap_static & s_pins.dat;
    assign mute_right  = strap_static & s_pins.mode;

    AST_STRAP_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        (strap_static && $past(strap_static)) |-> (levels == LEVELS_DEFAULT && status == STATUS_DEFAULT))
        else $error("registers not at default in strap mode"); // R8
endmodule

// File: tb/ctl3w_rx_test.sv
`timescale 1ns/1ps
module ctl3w_rx_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap_static = 1'b0;
    logic ser_data = 1'b0;
    logic ser_mode = 1'b0;
    logic ser_clk = 1'b0;
    logic [5:0] vol_right, vol_left, bass_boost, treble;
    logic [1:0] op_mode, route_right, route_left;
    logic deemph, mute_left, mute_right;

    always #2.5 clk = ~clk;

    ctl3w_rx uut (
        .clk(clk), .rst(rst), .strap_static(strap_static),
        .ser_data(ser_data), .ser_mode(ser_mode), .ser_clk(ser_clk),
        .vol_right(vol_right), .vol_left(vol_left), .bass_boost(bass_boost),
        .treble(treble), .op_mode(op_mode), .deemph(deemph),
        .route_right(route_right), .route_left(route_left),
        .mute_left(mute_left), .mute_right(mute_right)
    );

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    bit       m_sel = 0;
    bit [1:0] m_type = 0;
    bit [5:0] m_vr = 0, m_vl = 0, m_bs = 0, m_tr = 0;
    bit [1:0] m_mode = 0, m_rr = 0, m_rl = 0;
    bit       m_de = 0;
    bit       m_ml = 0, m_mr = 0;

    function automatic bit [7:0] make_addr(input bit [5:0] id, input bit [1:0] t);
        return {id, t};
    endfunction

    task automatic model_reset();
        m_sel = 0; m_type = 0;
        m_vr = 0; m_vl = 0; m_bs = 0; m_tr = 0;
        m_mode = 0; m_de = 0; m_rr = 0; m_rl = 0;
    endtask

    task automatic model_byte(input bit is_addr, input bit [7:0] b);
        if (is_addr) begin
            m_sel  = (b[7:2] == 6'b000101);
            m_type = b[1:0];
        end else if (m_sel) begin
            if (m_type == 2'b00) begin
                case (b[7:6])
                    2'b00: m_vr = b[5:0];
                    2'b01: m_vl = b[5:0];
                    2'b10: m_bs = b[5:0];
                    default: m_tr = b[5:0];
                endcase
            end else if (m_type == 2'b10 && !b[7]) begin
                m_mode = b[6:5]; m_de = b[4]; m_rr = b[3:2]; m_rl = b[1:0];
            end
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        chk(req, "vol_right", vol_right, m_vr);
        chk(req, "vol_left", vol_left, m_vl);
        chk(req, "bass_boost", bass_boost, m_bs);
        chk(req, "treble", treble, m_tr);
        chk(req, "op_mode", op_mode, m_mode);
        chk(req, "deemph", deemph, strap_static ? m_de : m_de);
        chk(req, "route_right", route_right, m_rr);
        chk(req, "route_left", route_left, m_rl);
        chk(req, "mute_left", mute_left, m_ml);
        chk(req, "mute_right", mute_right, m_mr);
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send_bits(input bit md, input bit [7:0] b, input int n);
        ser_mode = md;
        wait_clks(4);
        for (int i = 7; i > 7 - n; i--) begin
            ser_data = b[i];
            wait_clks(4);
            ser_clk = 1'b1;
            wait_clks(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send_byte(input bit md, input bit [7:0] b);
        send_bits(md, b, 8);
        model_byte(!md, b);
        wait_clks(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        wait_clks(4);
        rst = 1'b0;
        wait_clks(4);
        // R1 reset state
        check_all("R1");

        // R3 / R9: level group writes, asymmetric values check bit order
        send_byte(1'b0, make_addr(6'b000101, 2'b00));
        send_byte(1'b1, {2'b00, 6'b100001}); check_all("R3_vol_r_R9");
        send_byte(1'b1, {2'b01, 6'b000110}); check_all("R3_vol_l");
        send_byte(1'b1, {2'b10, 6'b110100}); check_all("R3_bass");
        send_byte(1'b1, {2'b11, 6'b011011}); check_all("R3_treble");
        // R6: more bytes under same selection
        send_byte(1'b1, {2'b00, 6'b111111}); check_all("R6");
        send_byte(1'b1, {2'b11, 6'b000001}); check_all("R6");

        // R4: status group
        send_byte(1'b0, make_addr(6'b000101, 2'b10));
        send_byte(1'b1, 8'b0_10_1_01_11); check_all("R4_write");
        send_byte(1'b1, 8'b1_01_0_10_00); check_all("R4_bit7_ignored");

        // R5: unused groups
        send_byte(1'b0, make_addr(6'b000101, 2'b01));
        send_byte(1'b1, 8'h15); check_all("R5_type01");
        send_byte(1'b0, make_addr(6'b000101, 2'b11));
        send_byte(1'b1, 8'hC9); check_all("R5_type11");

        // R2: wrong address deselects
        send_byte(1'b0, make_addr(6'b000100, 2'b00));
        send_byte(1'b1, {2'b01, 6'b101010}); check_all("R2_mismatch");
        send_byte(1'b0, make_addr(6'b100101, 2'b10));
        send_byte(1'b1, 8'h3F); check_all("R2_mismatch");

        // R7: partial byte dropped on mode change
        send_byte(1'b0, make_addr(6'b000101, 2'b00));
        send_bits(1'b1, 8'b10111111, 5);
        check_all("R7_partial_no_write");
        ser_mode = 1'b0; wait_clks(6);
        ser_mode = 1'b1; wait_clks(6);
        send_byte(1'b1, {2'b11, 6'b101010}); check_all("R7_realign");

        // R8: strap mode
        strap_static = 1'b1;
        model_reset();
        ser_data = 1'b1; ser_mode = 1'b0; ser_clk = 1'b1;
        m_ml = 1; m_mr = 0; m_de = 1;
        wait_clks(6); check_all("R8_pins_a");
        ser_data = 1'b0; ser_mode = 1'b1; ser_clk = 1'b0;
        m_ml = 0; m_mr = 1; m_de = 0;
        wait_clks(6); check_all("R8_pins_b");
        ser_mode = 1'b0; m_mr = 0;
        wait_clks(8);
        strap_static = 1'b0;
        wait_clks(4);
        send_byte(1'b1, {2'b00, 6'b010101}); check_all("R8_selection_cleared");

        // Random mix
        for (int n = 0; n < 250; n++) begin
            bit [7:0] b;
            if ($urandom_range(0, 3) == 0) begin
                b = make_addr(($urandom_range(0, 1) == 1) ? 6'b000101 : 6'($urandom),
                              2'($urandom));
                send_byte(1'b0, b);
            end else begin
                b = 8'($urandom);
                send_byte(1'b1, b);
            end
            check_all("R6_random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule